// File: doc/BRIEF.md
# Frame Pointer Adjust and Push Unit

This execution unit sits beside a small microcontroller core and owns the 14-bit software-stack pointer. It accepts one 16-bit instruction word at a time and recognises three single-word operations:
- **Add-and-return** adds a 6-bit literal to the pointer, then returns from a subroutine.
- **Subtract-and-return** subtracts a 6-bit literal from the pointer, then returns from a subroutine.
- **Push** stores an 8-bit literal at the address the pointer holds, then moves the pointer down by one.

On a return, the unit pops the return stack and loads the program counter with the popped value. It then spends one idle cycle during which it takes no new word. Any word that is none of the three operations is consumed and has no effect. The unit touches no status flags.

The instruction input is a valid/ready stream. The unit raises `insn_ready` only in these conditions:
- it is not in the idle slot that follows a return;
- `ptr_wr_en` is low;
- for a push, the data-memory write port also shows `dm_wr_ready`.

`insn_ready` may depend on `insn_valid` and `insn_word`. The data-memory write port is also valid/ready, and the unit is the sender:
- `dm_wr_valid` is raised for a push word offered while the unit is free, whatever the state of `dm_wr_ready`.
- The word, address and data stay unchanged for as long as the core holds `insn_valid`.
- The write and the pointer decrement take effect on the same edge as the handshake.

The core's general register path loads the pointer through `ptr_wr_en` and `ptr_wr_val`. That load takes priority and blocks instruction acceptance in its cycle. The return-stack pop, the program-counter load and `busy` are plain control pins.

Top module: `sfp_unit`

## Requirements
- R1: After reset, `frame_ptr` equals the parameter `RESET_PTR` (default 0), `busy` is 0, and `dm_wr_valid`, `rs_pop` and `pc_load_en` are 0 while no word is offered.
- R2: A word whose bits [15:6] are 1110100011 is add-and-return. The edge that accepts it sets `frame_ptr` to (`frame_ptr` + bits [5:0]) modulo 2^14.
- R3: A word whose bits [15:6] are 1110100111 is subtract-and-return. The edge that accepts it sets `frame_ptr` to (`frame_ptr` − bits [5:0]) modulo 2^14.
- R4: In the cycle that a return word is accepted, `rs_pop` and `pc_load_en` are 1 and `pc_load_val` equals `rs_top`. In the next cycle both are 0, and no data-memory write is requested.
- R5: In the cycle after a return is accepted, `busy` is 1 and `insn_ready` is 0, with no write, pop or pointer change. One cycle later `busy` is 0.
- R6: A word whose bits [15:8] are 11111010 is push. While it is offered and the unit is free, `dm_wr_valid` is 1, `dm_wr_addr` equals `frame_ptr` and `dm_wr_data` equals bits [7:0]. On the accepting edge `frame_ptr` becomes (`frame_ptr` − 1) modulo 2^14, so a push completes in one cycle.
- R7: While a push is offered and `dm_wr_ready` is 0, `insn_ready` is 0, `dm_wr_valid` stays 1 and `frame_ptr` does not change.
- R8: A word matching none of the three patterns is accepted when the unit is free, with no write request, no pop, no program-counter load and no change of `frame_ptr`.
- R9: When `ptr_wr_en` is 1, `insn_ready` and `dm_wr_valid` are 0, and on the next edge `frame_ptr` takes `ptr_wr_val`.
- R10: All pointer arithmetic wraps at 14 bits: push at 0 gives 3FFFh, add past 3FFFh wraps to low values, and subtract below 0 wraps to high values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit takes the offered word this cycle |
| insn_word | input | 16 | Instruction word |
| dm_wr_valid | output | 1 | Data-memory write requested |
| dm_wr_ready | input | 1 | Data memory accepts the write |
| dm_wr_addr | output | PTR_W (14) | Write address, the current pointer |
| dm_wr_data | output | 8 | Write data, the push literal |
| rs_pop | output | 1 | Pop one entry from the return stack |
| rs_top | input | PC_W (21) | Current top of the return stack |
| pc_load_en | output | 1 | Load the program counter |
| pc_load_val | output | PC_W (21) | Program counter value to load |
| busy | output | 1 | Idle slot after a return |
| ptr_wr_en | input | 1 | Load the pointer from the register path |
| ptr_wr_val | input | PTR_W (14) | Value for the pointer load |
| frame_ptr | output | PTR_W (14) | Current pointer value |

## Verification
A wrong pointer value shows on `frame_ptr` one cycle after the accepting edge. It also shows, in the same cycle, as the write address of the next push. A sequencer stuck in its idle slot, or one that leaves it too early, shows on `insn_ready` and `busy` in the cycle after a return: the unit either refuses words indefinitely or accepts one a cycle early. A decode slip, such as a near-miss word taken as an operation, shows at once as a spurious `dm_wr_valid` or `rs_pop`, or as a pointer change on the next edge. Random streams mix all three operations, unmatched words and write back-pressure, and start from pointer values near both wrap edges.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int INSN_W = 16;
  localparam int LIT_W  = 8;
  localparam int RLIT_W = 6;

  localparam logic [9:0] ADDRET_PFX = 10'b1110_1000_11;
  localparam logic [9:0] SUBRET_PFX = 10'b1110_1001_11;
  localparam logic [7:0] PUSH_PFX   = 8'b1111_1010;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_ADDRET,
    OP_SUBRET,
    OP_PUSH
  } sfp_op_e;

  typedef struct packed {
    sfp_op_e          op;
    logic [LIT_W-1:0] lit;
  } sfp_dec_t;

  typedef enum logic {
    ST_FREE,
    ST_SLOT
  } sfp_state_e;
endpackage

// File: rtl/sfp_decode.sv
module sfp_decode
  import sfp_pkg::*;
(
  input  logic [INSN_W-1:0] word_i,
  output sfp_dec_t          dec_o
);
  localparam int PAD_W = LIT_W - RLIT_W;

  logic hit_add;
  logic hit_sub;
  logic hit_push;

  assign hit_add  = (word_i[INSN_W-1 -: 10] == ADDRET_PFX);
  assign hit_sub  = (word_i[INSN_W-1 -: 10] == SUBRET_PFX);
  assign hit_push = (word_i[INSN_W-1 -: 8]  == PUSH_PFX);

  always_comb begin
    dec_o.op  = OP_NONE;
    dec_o.lit = '0;
    if (hit_add) begin
      dec_o.op  = OP_ADDRET;
      dec_o.lit = {{PAD_W{1'b0}}, word_i[RLIT_W-1:0]};
    end else if (hit_sub) begin
      dec_o.op  = OP_SUBRET;
      dec_o.lit = {{PAD_W{1'b0}}, word_i[RLIT_W-1:0]};
    end else if (hit_push) begin
      dec_o.op  = OP_PUSH;
      dec_o.lit = word_i[LIT_W-1:0];
    end
  end

  always_comb begin
    assert_dec_onehot_R8: assert ($onehot0({hit_add, hit_sub, hit_push}));
  end
endmodule

// File: rtl/sfp_seq.sv
module sfp_seq
  import sfp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    insn_valid_i,
  input  sfp_op_e op_i,
  input  logic    dm_wr_ready_i,
  input  logic    ptr_wr_en_i,
  output logic    insn_ready_o,
  output logic    accept_o,
  output logic    dm_wr_valid_o,
  output logic    ret_fire_o,
  output logic    busy_o
);
  sfp_state_e state_q;
  sfp_state_e state_d;
  logic       free;
  logic       is_ret;
  logic       is_push;

  assign free    = (state_q == ST_FREE) && !ptr_wr_en_i;
  assign is_ret  = (op_i == OP_ADDRET) || (op_i == OP_SUBRET);
  assign is_push = (op_i == OP_PUSH);

  assign insn_ready_o  = free && (!is_push || dm_wr_ready_i);
  assign accept_o      = insn_valid_i && insn_ready_o;
  assign dm_wr_valid_o = insn_valid_i && free && is_push;
  assign ret_fire_o    = accept_o && is_ret;
  assign busy_o        = (state_q == ST_SLOT);

  always_comb begin
    state_d = ST_FREE;
    if (state_q == ST_FREE && ret_fire_o) state_d = ST_SLOT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_FREE;
    else        state_q <= state_d;
  end

  assert_pop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire_o |=> !ret_fire_o);
  assert_slot_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire_o |=> (busy_o && !insn_ready_o && !dm_wr_valid_o));
  assert_slot_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);
endmodule

// File: rtl/sfp_ptr.sv
module sfp_ptr
  import sfp_pkg::*;
#(
  parameter int                PTR_W     = 14,
  parameter logic [PTR_W-1:0]  RESET_PTR = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             step_en_i,
  input  sfp_op_e          op_i,
  input  logic [LIT_W-1:0] lit_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam int EXT_W = PTR_W - LIT_W;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] lit_ext;

  assign lit_ext = {{EXT_W{1'b0}}, lit_i};

  always_comb begin
    ptr_d = ptr_q;
    if (load_en_i) begin
      ptr_d = load_val_i;
    end else if (step_en_i) begin
      unique case (op_i)
        OP_ADDRET: ptr_d = ptr_q + lit_ext;
        OP_SUBRET: ptr_d = ptr_q - lit_ext;
        OP_PUSH:   ptr_d = ptr_q - PTR_W'(1);
        default:   ptr_d = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= RESET_PTR;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> ptr_o == $past(load_val_i));
  assert_push_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && !load_en_i && op_i == OP_PUSH) |=> ptr_o == $past(ptr_o) - PTR_W'(1));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en_i && !load_en_i) |=> $stable(ptr_o));
endmodule

// File: rtl/sfp_unit.sv
module sfp_unit
  import sfp_pkg::*;
#(
  parameter int               PTR_W     = 14,
  parameter int               PC_W      = 21,
  parameter logic [PTR_W-1:0] RESET_PTR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic [INSN_W-1:0] insn_word,
  output logic              dm_wr_valid,
  input  logic              dm_wr_ready,
  output logic [PTR_W-1:0]  dm_wr_addr,
  output logic [LIT_W-1:0]  dm_wr_data,
  output logic              rs_pop,
  input  logic [PC_W-1:0]   rs_top,
  output logic              pc_load_en,
  output logic [PC_W-1:0]   pc_load_val,
  output logic              busy,
  input  logic              ptr_wr_en,
  input  logic [PTR_W-1:0]  ptr_wr_val,
  output logic [PTR_W-1:0]  frame_ptr
);
  sfp_dec_t dec;
  logic     accept;
  logic     ret_fire;

  sfp_decode u_dec (
    .word_i (insn_word),
    .dec_o  (dec)
  );

  sfp_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_valid_i  (insn_valid),
    .op_i          (dec.op),
    .dm_wr_ready_i (dm_wr_ready),
    .ptr_wr_en_i   (ptr_wr_en),
    .insn_ready_o  (insn_ready),
    .accept_o      (accept),
    .dm_wr_valid_o (dm_wr_valid),
    .ret_fire_o    (ret_fire),
    .busy_o        (busy)
  );

  sfp_ptr #(
    .PTR_W     (PTR_W),
    .RESET_PTR (RESET_PTR)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en_i  (ptr_wr_en),
    .load_val_i (ptr_wr_val),
    .step_en_i  (accept),
    .op_i       (dec.op),
    .lit_i      (dec.lit),
    .ptr_o      (frame_ptr)
  );

  assign dm_wr_addr  = frame_ptr;
  assign dm_wr_data  = dec.lit;
  assign rs_pop      = ret_fire;
  assign pc_load_en  = ret_fire;
  assign pc_load_val = rs_top;

  assert_addret_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_pop && insn_word[15:6] == ADDRET_PFX) |=>
      frame_ptr == $past(frame_ptr) + PTR_W'($past(insn_word[5:0])));
  assert_subret_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_pop && insn_word[15:6] == SUBRET_PFX) |=>
      frame_ptr == $past(frame_ptr) - PTR_W'($past(insn_word[5:0])));
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_wr_valid && !dm_wr_ready) |=> $stable(frame_ptr));
  assert_nowrite_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!dm_wr_valid && !rs_pop && !pc_load_en));
  assert_load_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |-> (!insn_ready && !dm_wr_valid));
  assert_push_no_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dm_wr_valid |-> !rs_pop);
endmodule

// File: tb/tb_sfp_unit.sv
module tb_sfp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 14;
  localparam int PC_W  = 21;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              insn_valid;
  logic              insn_ready;
  logic [15:0]       insn_word;
  logic              dm_wr_valid;
  logic              dm_wr_ready;
  logic [PTR_W-1:0]  dm_wr_addr;
  logic [7:0]        dm_wr_data;
  logic              rs_pop;
  logic [PC_W-1:0]   rs_top;
  logic              pc_load_en;
  logic [PC_W-1:0]   pc_load_val;
  logic              busy;
  logic              ptr_wr_en;
  logic [PTR_W-1:0]  ptr_wr_val;
  logic [PTR_W-1:0]  frame_ptr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfp_unit #(.PTR_W(PTR_W), .PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .dm_wr_valid(dm_wr_valid), .dm_wr_ready(dm_wr_ready),
    .dm_wr_addr(dm_wr_addr), .dm_wr_data(dm_wr_data), .rs_pop(rs_pop),
    .rs_top(rs_top), .pc_load_en(pc_load_en), .pc_load_val(pc_load_val),
    .busy(busy), .ptr_wr_en(ptr_wr_en), .ptr_wr_val(ptr_wr_val),
    .frame_ptr(frame_ptr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 unmatched, 1 add-return, 2 subtract-return, 3 push (encodings of R2, R3, R6)
  function automatic int kind_of(input logic [15:0] w);
    if (w[15:6] == 10'b1110100011) return 1;
    if (w[15:6] == 10'b1110100111) return 2;
    if (w[15:8] == 8'b11111010)    return 3;
    return 0;
  endfunction

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p, input logic [15:0] w);
    case (kind_of(w))
      1:       return p + PTR_W'(w[5:0]);
      2:       return p - PTR_W'(w[5:0]);
      3:       return p - PTR_W'(1);
      default: return p;
    endcase
  endfunction

  task automatic load_ptr(input logic [PTR_W-1:0] v);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_val = v;
    insn_valid = 1'b1; insn_word = 16'hFA55; dm_wr_ready = 1'b1;
    #1;
    chk(!insn_ready && !dm_wr_valid, "R9 blocked", {insn_ready, dm_wr_valid}, 0);
    @(posedge clk); #1;
    ptr_wr_en = 1'b0; insn_valid = 1'b0;
    chk(frame_ptr == v, "R9 load", frame_ptr, v);
  endtask

  task automatic run(input logic [15:0] w, input bit stall, input string req);
    int k = kind_of(w);
    logic [PTR_W-1:0] p0 = frame_ptr;
    logic [PTR_W-1:0] pe = next_ptr(p0, w);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w; dm_wr_ready = !stall;
    rs_top = PC_W'($urandom);
    #1;
    if (k == 3 && stall) begin
      chk(!insn_ready && dm_wr_valid, "R7 stall", {insn_ready, dm_wr_valid}, 1);
      @(negedge clk);
      chk(frame_ptr == p0, "R7 hold", frame_ptr, p0);
      chk(dm_wr_valid && dm_wr_addr == p0, "R7 valid held", dm_wr_addr, p0);
      dm_wr_ready = 1'b1;
      #1;
    end
    if (k == 1 || k == 2) begin
      chk(insn_ready && rs_pop && pc_load_en && !dm_wr_valid, "R4 pop", {insn_ready, rs_pop, pc_load_en, dm_wr_valid}, 4'b1110);
      chk(pc_load_val == rs_top, "R4 pc", pc_load_val, rs_top);
    end else if (k == 3) begin
      chk(insn_ready && dm_wr_valid && !rs_pop, "R6 write", {insn_ready, dm_wr_valid, rs_pop}, 3'b110);
      chk(dm_wr_addr == p0 && dm_wr_data == w[7:0], "R6 addr/data", {dm_wr_addr, dm_wr_data}, {p0, w[7:0]});
    end else begin
      chk(insn_ready && !dm_wr_valid && !rs_pop && !pc_load_en, "R8 ignored", {insn_ready, dm_wr_valid, rs_pop, pc_load_en}, 4'b1000);
    end
    @(posedge clk); #1;
    insn_valid = 1'b0;
    #1;
    chk(frame_ptr == pe, req, frame_ptr, pe);
    if (k == 1 || k == 2) begin
      insn_valid = 1'b1; insn_word = 16'hFA00; dm_wr_ready = 1'b1;
      #1;
      chk(busy && !insn_ready && !rs_pop && !pc_load_en && !dm_wr_valid, "R5 slot",
          {busy, insn_ready, rs_pop, pc_load_en, dm_wr_valid}, 5'b10000);
      @(posedge clk); #1;
      insn_valid = 1'b0;
      chk(frame_ptr == pe, "R5 no change", frame_ptr, pe);
      #1;
      chk(!busy, "R5 slot ends", busy, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd1234));
    rst_n = 1'b0; insn_valid = 1'b0; insn_word = '0; dm_wr_ready = 1'b0;
    rs_top = '0; ptr_wr_en = 1'b0; ptr_wr_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(frame_ptr == 0 && !busy && !dm_wr_valid && !rs_pop && !pc_load_en, "R1 reset",
        {frame_ptr, busy, dm_wr_valid, rs_pop, pc_load_en}, 0);

    load_ptr(14'h03FF); run(16'hE8E3, 0, "R2 add vector");
    chk(frame_ptr == 14'h0422, "R2 3FF+23", frame_ptr, 14'h0422);
    load_ptr(14'h03FF); run(16'hE9E3, 0, "R3 sub vector");
    chk(frame_ptr == 14'h03DC, "R3 3FF-23", frame_ptr, 14'h03DC);
    load_ptr(14'h01EC); run(16'hFA08, 0, "R6 push vector");
    chk(frame_ptr == 14'h01EB, "R6 1EC-1", frame_ptr, 14'h01EB);
    load_ptr(14'h0000); run(16'hFA77, 0, "R10 push wrap");
    chk(frame_ptr == 14'h3FFF, "R10 0-1", frame_ptr, 14'h3FFF);
    load_ptr(14'h3FF0); run(16'hE8FF, 0, "R10 add wrap");
    chk(frame_ptr == 14'h002F, "R10 3FF0+3F", frame_ptr, 14'h002F);
    load_ptr(14'h0010); run(16'hE9FF, 0, "R10 sub wrap");
    chk(frame_ptr == 14'h3FD1, "R10 10-3F", frame_ptr, 14'h3FD1);
    load_ptr(14'h0100);
    run(16'hE8A5, 0, "R8 near add");
    run(16'hE9BF, 0, "R8 near sub");
    run(16'hFB12, 0, "R8 near push");
    run(16'hFA3C, 1, "R7 push after stall");

    for (int i = 0; i < 400; i++) begin
      int sel = int'($urandom % 5);
      case (sel)
        0: w = {10'b1110100011, 6'($urandom)};
        1: w = {10'b1110100111, 6'($urandom)};
        2: w = {8'b11111010, 8'($urandom)};
        default: w = 16'($urandom);
      endcase
      if (i % 50 == 0) load_ptr(14'($urandom));
      run(w, ($urandom % 3) == 0, "R2/R3/R6/R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule